// File: doc/BRIEF.md
# Speculative Load Tracker

This block supports loads that a compiler has moved above stores that might write the same bytes. When such a load issues, the block records its byte range and a tag for the register it writes. Every store that follows is compared in parallel with all live records, and any record whose bytes overlap the store is dropped. Later, at the load's original position in the program, a check names the register tag. The block answers whether the early value can still be used, or whether the load must be repeated or control must jump to recovery code.

The table is fully associative. The number of records, the address width and the tag width are parameters. A load that was also moved above a branch carries an extra flag. Apart from that flag it is recorded in the same way, and the flag is returned on a successful check. A flush input drops every record at once. One cycle applies its events in a fixed order: store and flush invalidation first, then the check lookup, then the new allocation. The check answer is registered and appears one cycle after the query, together with a strobe.

Top module: `spec_load_tracker`

## Requirements
- R1: When `alloc_en` is high, the block records the address, size code, tag and flag at the next clock edge, and the record is valid. A later check of that tag finds it, provided nothing has invalidated it.
- R2: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes starting at the given address. A store invalidates every valid record whose byte range shares at least one byte with the store's range. A record whose range only touches the store's range at the edge stays valid.
- R3: A load-form check (`chk_form` = 0) gives `res_reload` = 0 when a valid record holds the tag and `res_reload` = 1 when none does. In both cases `res_recover` = 0.
- R4: A branch-form check (`chk_form` = 1) gives `res_recover` = 1 when no valid record holds the tag and 0 when one does. In both cases `res_reload` = 0.
- R5: `res_spec` returns the branch-hoist flag of the record that a check finds. On a miss it is 0.
- R6: Allocating a tag that a valid record already holds overwrites that record. A tag is never held by two valid records. A store to the old range then has no effect on the tag.
- R7: Allocation takes an invalid record, lowest index first, when one exists. When the table is full, it replaces records in round-robin order starting at index 0 after reset. The replaced tag then misses on its next check.
- R8: Events in one cycle apply in this order: store invalidation, then check lookup, then allocation. A check sees a store from the same cycle. A check does not see an allocation from the same cycle. A record allocated in the same cycle as an overlapping store stays valid.
- R9: A check with `chk_clear` = 1 reports the record's state before the check and then invalidates the record. Without `chk_clear` the record stays valid.
- R10: `flush` invalidates every record in one cycle. A check in the same cycle sees all records as invalid.
- R11: `res_valid` is high exactly one cycle after a cycle with `chk_en` high. While `res_valid` is low, `res_reload`, `res_recover` and `res_spec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Record a hoisted load |
| alloc_addr | input | ADDR_W | First byte address of the load |
| alloc_size | input | 2 | Size code of the load (0..3 = 1, 2, 4, 8 bytes) |
| alloc_tag | input | TAG_W | Destination register tag |
| alloc_br_hoist | input | 1 | Load was also moved above a branch |
| st_en | input | 1 | Store snoop strobe |
| st_addr | input | ADDR_W | First byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_en | input | 1 | Check query strobe |
| chk_tag | input | TAG_W | Register tag to check |
| chk_form | input | 1 | 0 = load form, 1 = branch form |
| chk_clear | input | 1 | Invalidate the record after the lookup |
| flush | input | 1 | Invalidate all records |
| res_valid | output | 1 | Check answer strobe |
| res_reload | output | 1 | Load form: value must be reloaded |
| res_recover | output | 1 | Branch form: jump to recovery |
| res_spec | output | 1 | Branch-hoist flag of the record that was found |

## Verification
The assertions rely on the caller never holding two records for one tag by any route other than allocation. The allocator guarantees this, so the uniqueness check on a lookup holds for any input sequence. The assertions do not depend on the input strobes being exclusive: any mix of allocate, store, check and flush may occur in one cycle. The directed stimulus combines them on purpose to exercise the ordering rule. The round-robin scenario runs first after reset, so the replacement pointer starts from a known position without the bench having to read it.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

  localparam int unsigned WIDE_ADDR_W = 64;

  typedef enum logic {
    CHK_LOAD   = 1'b0,
    CHK_BRANCH = 1'b1
  } chk_form_e;

  // size code to byte count: 0->1, 1->2, 2->4, 3->8
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // true when the two byte ranges share at least one byte
  function automatic logic ranges_overlap(
    input logic [WIDE_ADDR_W-1:0] a_base,
    input logic [1:0]             a_code,
    input logic [WIDE_ADDR_W-1:0] b_base,
    input logic [1:0]             b_code
  );
    logic [WIDE_ADDR_W:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, a_base};
    b_lo = {1'b0, b_base};
    a_hi = a_lo + (WIDE_ADDR_W+1)'(span_bytes(a_code)) - (WIDE_ADDR_W+1)'(1);
    b_hi = b_lo + (WIDE_ADDR_W+1)'(span_bytes(b_code)) - (WIDE_ADDR_W+1)'(1);
    return (a_lo <= b_hi) && (b_lo <= a_hi);
  endfunction

endpackage

// File: rtl/spec_load_entry.sv
module spec_load_entry
  import spec_load_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TAG_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_br_hoist,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              flush,
  input  logic              chk_kill,
  output logic              valid_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic              br_hoist_q,
  output logic              snoop_hit,
  output logic              live
);

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              valid_d;

  // stage 1: store snoop and flush
  assign snoop_hit = st_en && valid_q &&
                     ranges_overlap(WIDE_ADDR_W'(st_addr), st_size,
                                    WIDE_ADDR_W'(addr_q), size_q);
  assign live      = valid_q && !snoop_hit && !flush;

  // stage 3: allocation wins over everything before it
  assign valid_d   = wr_en || (live && !chk_kill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      addr_q     <= '0;
      size_q     <= '0;
      tag_q      <= '0;
      br_hoist_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (wr_en) begin
        addr_q     <= wr_addr;
        size_q     <= wr_size;
        tag_q      <= wr_tag;
        br_hoist_q <= wr_br_hoist;
      end
    end
  end

  assert_write_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q && tag_q == $past(wr_tag) && br_hoist_q == $past(wr_br_hoist)));

  assert_store_kills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !wr_en) |=> !valid_q);

  assert_flush_kills_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> !valid_q);

  assert_clear_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_kill && !wr_en) |=> !valid_q);

endmodule

// File: rtl/spec_load_alloc.sv
module spec_load_alloc #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic [ENTRIES-1:0] keep,
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  output logic [ENTRIES-1:0] wr_vec,
  output logic               use_reuse,
  output logic               use_free,
  output logic               use_rr
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] reuse_vec;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] free_first;
  logic [IDX_W-1:0]   rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign reuse_vec[g] = keep[g] && (tags[g] == alloc_tag);
    assign free_vec[g]  = !keep[g];
  end

  // lowest-index free record
  always_comb begin
    logic found;
    found      = 1'b0;
    free_first = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_vec[i] && !found) begin
        free_first[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign use_reuse = alloc_en && (|reuse_vec);
  assign use_free  = alloc_en && !(|reuse_vec) && (|free_vec);
  assign use_rr    = alloc_en && !(|reuse_vec) && !(|free_vec);

  always_comb begin
    wr_vec = '0;
    if (use_reuse) begin
      wr_vec = reuse_vec;
    end else if (use_free) begin
      wr_vec = free_first;
    end else if (use_rr) begin
      for (int i = 0; i < ENTRIES; i++) begin
        wr_vec[i] = (IDX_W'(i) == rr_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (use_rr) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES-1)) ? '0 : rr_ptr + IDX_W'(1);
    end
  end

  assert_alloc_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> ($countones(wr_vec) == 1));

  assert_alloc_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_en |-> (wr_vec == '0));

  assert_free_before_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    use_free |-> ((wr_vec & keep) == '0));

  assert_reuse_same_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    use_reuse |-> ($countones(wr_vec & keep) == 1));

endmodule

// File: rtl/spec_load_check.sv
module spec_load_check
  import spec_load_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic [TAG_W-1:0]   chk_tag,
  input  chk_form_e          chk_form,
  input  logic               chk_clear,
  input  logic [ENTRIES-1:0] live,
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] br_hoist,
  output logic [ENTRIES-1:0] kill_vec,
  output logic               lookup_hit,
  output logic               res_valid,
  output logic               res_reload,
  output logic               res_recover,
  output logic               res_spec
);

  logic [ENTRIES-1:0] hit_vec;

  // stage 2: lookup sees the post-invalidation view
  for (genvar g = 0; g < ENTRIES; g++) begin : g_hit
    assign hit_vec[g]  = live[g] && (tags[g] == chk_tag);
    assign kill_vec[g] = chk_en && chk_clear && hit_vec[g];
  end

  assign lookup_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_reload  <= 1'b0;
      res_recover <= 1'b0;
      res_spec    <= 1'b0;
    end else begin
      res_valid   <= chk_en;
      res_reload  <= chk_en && (chk_form == CHK_LOAD)   && !lookup_hit;
      res_recover <= chk_en && (chk_form == CHK_BRANCH) && !lookup_hit;
      res_spec    <= chk_en && (|(hit_vec & br_hoist));
    end
  end

  assert_tag_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(hit_vec));

  assert_strobe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |=> res_valid);

  assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> !res_valid);

  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_reload || res_recover || res_spec));

  assert_forms_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_reload && res_recover));

  assert_hit_no_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && lookup_hit) |=> (!res_reload && !res_recover));

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
  import spec_load_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_size,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_br_hoist,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_en,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_form,
  input  logic              chk_clear,
  input  logic              flush,
  output logic              res_valid,
  output logic              res_reload,
  output logic              res_recover,
  output logic              res_spec
);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] live_vec;
  logic [ENTRIES-1:0] snoop_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] keep_vec;
  logic [ENTRIES-1:0] wr_vec;
  logic [ENTRIES-1:0] hoist_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  logic               use_reuse, use_free, use_rr;
  logic               lookup_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    spec_load_entry #(
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_vec[g]),
      .wr_addr     (alloc_addr),
      .wr_size     (alloc_size),
      .wr_tag      (alloc_tag),
      .wr_br_hoist (alloc_br_hoist),
      .st_en       (st_en),
      .st_addr     (st_addr),
      .st_size     (st_size),
      .flush       (flush),
      .chk_kill    (kill_vec[g]),
      .valid_q     (valid_vec[g]),
      .tag_q       (tag_arr[g]),
      .br_hoist_q  (hoist_vec[g]),
      .snoop_hit   (snoop_vec[g]),
      .live        (live_vec[g])
    );
  end

  assign keep_vec = live_vec & ~kill_vec;

  spec_load_check #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W)
  ) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .chk_tag     (chk_tag),
    .chk_form    (chk_form_e'(chk_form)),
    .chk_clear   (chk_clear),
    .live        (live_vec),
    .tags        (tag_arr),
    .br_hoist    (hoist_vec),
    .kill_vec    (kill_vec),
    .lookup_hit  (lookup_hit),
    .res_valid   (res_valid),
    .res_reload  (res_reload),
    .res_recover (res_recover),
    .res_spec    (res_spec)
  );

  spec_load_alloc #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W)
  ) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_tag (alloc_tag),
    .keep      (keep_vec),
    .tags      (tag_arr),
    .wr_vec    (wr_vec),
    .use_reuse (use_reuse),
    .use_free  (use_free),
    .use_rr    (use_rr)
  );

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !alloc_en) |=> (valid_vec == '0));

  assert_flush_blinds_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !lookup_hit);

  assert_snoop_only_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_vec & ~valid_vec) == '0);

  assert_evict_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    use_rr |-> (keep_vec == '1));

  assert_one_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({use_reuse, use_free, use_rr}));

endmodule

// File: tb/spec_load_tracker_bench.sv
`timescale 1ns/1ps
module spec_load_tracker_bench;

  localparam int unsigned ENTRIES = 16;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned TAG_W   = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_en, alloc_br_hoist;
  logic [ADDR_W-1:0] alloc_addr;
  logic [1:0]        alloc_size;
  logic [TAG_W-1:0]  alloc_tag;
  logic              st_en;
  logic [ADDR_W-1:0] st_addr;
  logic [1:0]        st_size;
  logic              chk_en, chk_form, chk_clear, flush;
  logic [TAG_W-1:0]  chk_tag;
  logic              res_valid, res_reload, res_recover, res_spec;

  int tests_run  = 0;
  int tests_fail = 0;
  bit done       = 1'b0;

  always #2 clk = ~clk;

  spec_load_tracker #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W)
  ) u_spec_load_tracker (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_en       (alloc_en),
    .alloc_addr     (alloc_addr),
    .alloc_size     (alloc_size),
    .alloc_tag      (alloc_tag),
    .alloc_br_hoist (alloc_br_hoist),
    .st_en          (st_en),
    .st_addr        (st_addr),
    .st_size        (st_size),
    .chk_en         (chk_en),
    .chk_tag        (chk_tag),
    .chk_form       (chk_form),
    .chk_clear      (chk_clear),
    .flush          (flush),
    .res_valid      (res_valid),
    .res_reload     (res_reload),
    .res_recover    (res_recover),
    .res_spec       (res_spec)
  );

  // ---------- low-level drivers (all called at a falling edge) ----------
  task automatic quiet();
    alloc_en = 0; alloc_br_hoist = 0; alloc_addr = '0; alloc_size = '0; alloc_tag = '0;
    st_en = 0; st_addr = '0; st_size = '0;
    chk_en = 0; chk_tag = '0; chk_form = 0; chk_clear = 0; flush = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic set_alloc(input int addr, input int sz, input int tag, input bit hoist);
    alloc_en = 1; alloc_addr = ADDR_W'(addr); alloc_size = 2'(sz);
    alloc_tag = TAG_W'(tag); alloc_br_hoist = hoist;
  endtask

  task automatic set_store(input int addr, input int sz);
    st_en = 1; st_addr = ADDR_W'(addr); st_size = 2'(sz);
  endtask

  task automatic set_chk(input int tag, input bit form, input bit clr);
    chk_en = 1; chk_tag = TAG_W'(tag); chk_form = form; chk_clear = clr;
  endtask

  task automatic expect_res(input string req, input bit e_rel, input bit e_rec, input bit e_spec);
    tests_run++;
    if (res_valid !== 1'b1 || res_reload !== e_rel || res_recover !== e_rec || res_spec !== e_spec) begin
      tests_fail++;
      $display("FAIL %s: got valid=%b reload=%b recover=%b spec=%b, expected valid=1 reload=%b recover=%b spec=%b",
               req, res_valid, res_reload, res_recover, res_spec, e_rel, e_rec, e_spec);
    end
  endtask

  task automatic expect_idle(input string req);
    tests_run++;
    if (res_valid !== 1'b0 || res_reload !== 1'b0 || res_recover !== 1'b0 || res_spec !== 1'b0) begin
      tests_fail++;
      $display("FAIL %s: got valid=%b reload=%b recover=%b spec=%b, expected all 0",
               req, res_valid, res_reload, res_recover, res_spec);
    end
  endtask

  task automatic alloc(input int addr, input int sz, input int tag, input bit hoist);
    set_alloc(addr, sz, tag, hoist); tick();
  endtask

  task automatic store(input int addr, input int sz);
    set_store(addr, sz); tick();
  endtask

  // check and compare: result appears after one rising edge
  task automatic chk(input string req, input int tag, input bit form, input bit clr,
                     input bit e_rel, input bit e_rec, input bit e_spec);
    set_chk(tag, form, clr); tick();
    expect_res(req, e_rel, e_rec, e_spec);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    expect_idle("R11 reset");
    chk("R3 empty table load-form", 5, 0, 0, 1, 0, 0);
    tick();
    expect_idle("R11 strobe drops");
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < ENTRIES; i++) alloc(32'h1000 + 16*i, 2, i, 0);
    alloc(32'h2000, 2, 20, 0);                   // evicts record 0 (tag 0)
    chk("R7 evicted tag recovers", 0, 1, 0, 0, 1, 0);
    chk("R7 next tag survives", 1, 0, 0, 0, 0, 0);
    chk("R7 new tag present", 20, 0, 0, 0, 0, 0);
    alloc(32'h2100, 2, 21, 0);                   // evicts record 1 (tag 1)
    chk("R7 second eviction", 1, 0, 0, 1, 0, 0);
    chk("R7 tag 2 survives", 2, 0, 0, 0, 0, 0);
    set_flush_now();
    chk("R10 flush clears tag 2", 2, 0, 0, 1, 0, 0);
    chk("R10 flush clears tag 20", 20, 1, 0, 0, 1, 0);
  endtask

  task automatic set_flush_now();
    flush = 1; tick();
  endtask

  task automatic t_alloc_hit();
    alloc(32'h100, 3, 7, 0);                     // bytes 0x100..0x107
    chk("R1 R3 load-form hit", 7, 0, 0, 0, 0, 0);
    chk("R4 branch-form hit", 7, 1, 0, 0, 0, 0);
    tick();
    expect_idle("R11 idle after check");
  endtask

  task automatic t_overlap();
    store(32'h108, 0);                           // just above
    chk("R2 adjacent above keeps", 7, 0, 0, 0, 0, 0);
    store(32'hFF, 0);                            // just below
    chk("R2 adjacent below keeps", 7, 0, 0, 0, 0, 0);
    store(32'hFE, 2);                            // 0xFE..0x101 overlaps
    chk("R2 partial overlap kills", 7, 0, 0, 1, 0, 0);
    alloc(32'h200, 0, 8, 0);
    store(32'h1FC, 3);                           // 0x1FC..0x203 covers
    chk("R2 covering store kills", 8, 1, 0, 0, 1, 0);
    alloc(32'h300, 2, 9, 0);
    store(32'h304, 2);
    chk("R2 disjoint word keeps", 9, 1, 0, 0, 0, 0);
  endtask

  task automatic t_spec();
    alloc(32'h900, 1, 10, 1);
    chk("R5 hoist flag returned", 10, 0, 0, 0, 0, 1);
    alloc(32'h910, 1, 11, 0);
    chk("R5 plain load flag 0", 11, 1, 0, 0, 0, 0);
    chk("R5 miss flag 0", 12, 0, 0, 1, 0, 0);
  endtask

  task automatic t_reuse();
    alloc(32'h400, 0, 13, 0);
    alloc(32'h500, 0, 13, 0);
    store(32'h400, 0);
    chk("R6 old range ignored", 13, 0, 0, 0, 0, 0);
    store(32'h500, 0);
    chk("R6 new range tracked", 13, 0, 0, 1, 0, 0);
  endtask

  task automatic t_order();
    alloc(32'h600, 2, 14, 0);
    set_store(32'h600, 0); set_chk(14, 0, 0); tick();
    expect_res("R8 check sees same-cycle store", 1, 0, 0);
    set_alloc(32'h700, 2, 15, 0); set_chk(15, 1, 0); tick();
    expect_res("R8 check blind to same-cycle alloc", 0, 1, 0);
    chk("R8 alloc visible next cycle", 15, 1, 0, 0, 0, 0);
    set_alloc(32'h800, 2, 16, 0); set_store(32'h800, 2); tick();
    chk("R8 alloc survives same-cycle store", 16, 0, 0, 0, 0, 0);
  endtask

  task automatic t_clear();
    alloc(32'hA00, 2, 17, 0);
    chk("R9 no clear keeps", 17, 0, 0, 0, 0, 0);
    chk("R9 clear reports prior hit", 17, 0, 1, 0, 0, 0);
    chk("R9 cleared record gone", 17, 0, 0, 1, 0, 0);
  endtask

  task automatic t_flush_same();
    alloc(32'hB00, 2, 18, 0);
    flush = 1; set_chk(18, 1, 0); tick();
    expect_res("R10 check sees same-cycle flush", 0, 1, 0);
  endtask

  initial begin
    quiet();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_alloc_hit();
    t_overlap();
    t_spec();
    t_reuse();
    t_order();
    t_clear();
    t_flush_same();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule